// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block resolves control flow for a 64-bit register-based packet-filter instruction set. Each cycle it may accept one jump-class instruction: the 8-bit opcode, the value of the destination register, the value of the source register, the 32-bit immediate, the 16-bit signed offset and the current program counter. One clock later it reports whether the branch is taken, the next program counter, and strobes for a helper call, a program exit or an illegal encoding.

A conditional branch has only one target. When the condition is false, execution falls through to the next instruction. The block handles equality, bit-test, unsigned and signed relations. It supports two compare classes. The wide class compares full 64-bit values. The narrow class compares only the low 32 bits of each operand. Register reads and the handling of calls lie outside the block: it raises the call or exit strobe and leaves the action to the pipeline.

Top module: `branch_resolve`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises with no instruction, every output is zero.
- R2: An instruction presented with `in_valid` high produces its result one clock later, with `out_valid` high. A cycle with `in_valid` low yields `out_valid`, `taken`, `call_stb`, `exit_stb`, `illegal` and `next_pc` all zero one clock later.
- R3: Opcode bits [2:0] pick the class. Value 5 compares the full 64-bit operands. Value 6 compares only bits [31:0] of each operand, zero-extended for unsigned relations and sign-extended for signed ones. Any other class is illegal.
- R4: Opcode bit 3 set selects `src_val` as the second operand. Bit 3 clear selects the immediate, sign-extended to 64 bits.
- R5: Opcode bits [7:4] give the relation. EQ=0x1 takes the branch when the operands are equal. NE=0x5 takes it when they differ. SET=0x4 takes it when their bitwise AND is nonzero.
- R6: The unsigned relations are GT=0x2, GE=0x3, LT=0xA and LE=0xB. Each compares `dst_val` against the second operand.
- R7: The signed, two's-complement relations are SGT=0x6, SGE=0x7, SLT=0xC and SLE=0xD.
- R8: A taken branch yields `next_pc` = pc + 1 + sign-extended offset, modulo 2^PCW. Every other legal or illegal outcome yields pc + 1.
- R9: Relation code 0x0 in class 5 is an unconditional jump and is always taken.
- R10: Relation 0x8 in class 5 raises `call_stb`, and 0x9 in class 5 raises `exit_stb`. In both cases `taken` stays 0.
- R11: Codes 0x0, 0x8 and 0x9 in class 6, codes 0xE and 0xF in either class, and any class other than 5 or 6 raise `illegal`. `taken` and both strobes then stay 0.
- R12: At most one of `taken`, `call_stb`, `exit_stb` and `illegal` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Relation [7:4], source select [3], class [2:0] |
| dst_val | input | XLEN | Destination register value (first operand) |
| src_val | input | XLEN | Source register value |
| imm | input | 32 | Immediate field |
| offset | input | OFFW | Signed branch displacement in instructions |
| pc | input | PCW | Program counter of this instruction |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| next_pc | output | PCW | Next program counter |
| call_stb | output | 1 | Helper call requested |
| exit_stb | output | 1 | Program exit requested |
| illegal | output | 1 | Illegal jump encoding |

## Verification
The assertions compare results against the inputs of the previous cycle. They assume `pc`, `opcode` and `offset` are sampled at the clock edge where `in_valid` is high. They also assume the inputs carry defined values whenever `in_valid` is high. The bench meets both assumptions by changing inputs only on the falling edge and by holding each instruction for exactly one rising edge. It then drops `in_valid` before it samples the result. Operand values are picked so that wide and narrow compares, and signed and unsigned relations, disagree, so any mix-up between them shows in `taken`.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [2:0] {
        KIND_COND,
        KIND_JA,
        KIND_CALL,
        KIND_EXIT,
        KIND_BAD
    } brc_kind_e;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    localparam logic [3:0] OP_JA   = 4'h0;
    localparam logic [3:0] OP_EQ   = 4'h1;
    localparam logic [3:0] OP_GT   = 4'h2;
    localparam logic [3:0] OP_GE   = 4'h3;
    localparam logic [3:0] OP_SET  = 4'h4;
    localparam logic [3:0] OP_NE   = 4'h5;
    localparam logic [3:0] OP_SGT  = 4'h6;
    localparam logic [3:0] OP_SGE  = 4'h7;
    localparam logic [3:0] OP_CALL = 4'h8;
    localparam logic [3:0] OP_EXIT = 4'h9;
    localparam logic [3:0] OP_LT   = 4'hA;
    localparam logic [3:0] OP_LE   = 4'hB;
    localparam logic [3:0] OP_SLT  = 4'hC;
    localparam logic [3:0] OP_SLE  = 4'hD;
endpackage

// File: rtl/brc_decode.sv
module brc_decode
    import brc_pkg::*;
(
    input  logic [7:0] opcode,
    output brc_kind_e  kind,
    output logic       narrow,
    output logic       use_reg,
    output logic [3:0] rel
);
    logic [2:0] cls;

    always_comb begin
        cls     = opcode[2:0];
        rel     = opcode[7:4];
        use_reg = opcode[3];
        narrow  = (cls == CLS_NARROW);
        kind    = KIND_BAD;
        if (cls == CLS_WIDE || cls == CLS_NARROW) begin
            case (rel)
                OP_JA:   kind = narrow ? KIND_BAD : KIND_JA;
                OP_CALL: kind = narrow ? KIND_BAD : KIND_CALL;
                OP_EXIT: kind = narrow ? KIND_BAD : KIND_EXIT;
                OP_EQ, OP_NE, OP_SET,
                OP_GT, OP_GE, OP_LT, OP_LE,
                OP_SGT, OP_SGE, OP_SLT, OP_SLE: kind = KIND_COND;
                default: kind = KIND_BAD;
            endcase
        end
    end
endmodule

// File: rtl/brc_compare.sv
module brc_compare
    import brc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic [3:0]      rel,
    input  logic            narrow,
    output logic            hit
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] ua, ub, sa, sb;

    always_comb begin
        ua = narrow ? {{(XLEN-HALF){1'b0}}, lhs[HALF-1:0]} : lhs;
        ub = narrow ? {{(XLEN-HALF){1'b0}}, rhs[HALF-1:0]} : rhs;
        sa = narrow ? {{(XLEN-HALF){lhs[HALF-1]}}, lhs[HALF-1:0]} : lhs;
        sb = narrow ? {{(XLEN-HALF){rhs[HALF-1]}}, rhs[HALF-1:0]} : rhs;
        case (rel)
            OP_EQ:   hit = (ua == ub);
            OP_NE:   hit = (ua != ub);
            OP_SET:  hit = |(ua & ub);
            OP_GT:   hit = (ua > ub);
            OP_GE:   hit = (ua >= ub);
            OP_LT:   hit = (ua < ub);
            OP_LE:   hit = (ua <= ub);
            OP_SGT:  hit = ($signed(sa) > $signed(sb));
            OP_SGE:  hit = ($signed(sa) >= $signed(sb));
            OP_SLT:  hit = ($signed(sa) < $signed(sb));
            OP_SLE:  hit = ($signed(sa) <= $signed(sb));
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
    parameter int PCW  = 16,
    parameter int OFFW = 16
) (
    input  logic [PCW-1:0]  pc,
    input  logic [OFFW-1:0] offset,
    output logic [PCW-1:0]  fall_pc,
    output logic [PCW-1:0]  jump_pc
);
    logic [PCW-1:0] disp;

    generate
        if (PCW > OFFW) begin : g_extend
            assign disp = {{(PCW-OFFW){offset[OFFW-1]}}, offset};
        end else begin : g_trunc
            assign disp = offset[PCW-1:0];
        end
    endgenerate

    always_comb begin
        fall_pc = pc + PCW'(1);
        jump_pc = fall_pc + disp;
    end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import brc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int PCW  = 16,
    parameter int OFFW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      opcode,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [31:0]     imm,
    input  logic [OFFW-1:0] offset,
    input  logic [PCW-1:0]  pc,
    output logic            out_valid,
    output logic            taken,
    output logic [PCW-1:0]  next_pc,
    output logic            call_stb,
    output logic            exit_stb,
    output logic            illegal
);
    localparam int IMMW = 32;

    typedef struct packed {
        logic           vld;
        logic           tk;
        logic [PCW-1:0] npc;
        logic           cl;
        logic           ex;
        logic           il;
    } res_t;

    res_t res_d, res_q;

    brc_kind_e       kind;
    logic            narrow, use_reg, hit;
    logic [3:0]      rel;
    logic [XLEN-1:0] rhs;
    logic [PCW-1:0]  fall_pc, jump_pc;

    brc_decode u_dec (
        .opcode (opcode),
        .kind   (kind),
        .narrow (narrow),
        .use_reg(use_reg),
        .rel    (rel)
    );

    assign rhs = use_reg ? src_val : {{(XLEN-IMMW){imm[IMMW-1]}}, imm};

    brc_compare #(.XLEN(XLEN)) u_cmp (
        .lhs   (dst_val),
        .rhs   (rhs),
        .rel   (rel),
        .narrow(narrow),
        .hit   (hit)
    );

    brc_target #(.PCW(PCW), .OFFW(OFFW)) u_tgt (
        .pc     (pc),
        .offset (offset),
        .fall_pc(fall_pc),
        .jump_pc(jump_pc)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.vld = 1'b1;
            res_d.npc = fall_pc;
            case (kind)
                KIND_COND: begin
                    res_d.tk = hit;
                    if (hit) res_d.npc = jump_pc;
                end
                KIND_JA: begin
                    res_d.tk  = 1'b1;
                    res_d.npc = jump_pc;
                end
                KIND_CALL: res_d.cl = 1'b1;
                KIND_EXIT: res_d.ex = 1'b1;
                default:   res_d.il = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign taken     = res_q.tk;
    assign next_pc   = res_q.npc;
    assign call_stb  = res_q.cl;
    assign exit_stb  = res_q.ex;
    assign illegal   = res_q.il;

    // R12
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken, call_stb, exit_stb, illegal}));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !taken && !call_stb && !exit_stb && !illegal);

    // R8
    fall_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !(opcode[2:0] == 3'd5 && opcode[7:4] == 4'h0) ##1 !taken
        |-> next_pc == $past(pc) + PCW'(1));

    // R11
    bad_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode[2:0] != 3'd5 && opcode[2:0] != 3'd6 |=> illegal && !taken);

    // R9
    uncond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode == 8'h05 |=> taken && out_valid);

    // R10
    narrow_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode[2:0] == 3'd6 |=> !call_stb && !exit_stb);
endmodule

// File: tb/branch_resolve_bench.sv
module branch_resolve_bench;
    localparam int PCW = 16;

    typedef struct packed {
        logic [7:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [31:0] imm;
        logic [15:0] off;
        logic [15:0] pc;
        logic        tk;
        logic [15:0] npc;
        logic        cl;
        logic        ex;
        logic        il;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        // R5 EQ wide reg, equal
        '{8'h1d, 64'd5, 64'd5, 32'd0, 16'd4, 16'h0100, 1'b1, 16'h0105, 1'b0, 1'b0, 1'b0, 8'd5},
        // R5 EQ unequal
        '{8'h1d, 64'd5, 64'd6, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b0, 8'd5},
        // R4 NE imm, equal
        '{8'h55, 64'd7, 64'd0, 32'd7, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b0, 8'd4},
        // R5 SET no common bits
        '{8'h4d, 64'hF0, 64'h0F, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b0, 8'd5},
        // R3 SET narrow ignores upper halves
        '{8'h4e, 64'h1_0000_0000, 64'h1_0000_0000, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b0, 8'd3},
        // R6 GT unsigned all-ones > 1
        '{8'h2d, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 16'd4, 16'h0100, 1'b1, 16'h0105, 1'b0, 1'b0, 1'b0, 8'd6},
        // R7 SGT -1 > 1 false
        '{8'h6d, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b0, 8'd7},
        // R4 LT imm sign-extended to all ones
        '{8'ha5, 64'h1_0000_0000, 64'd0, 32'hFFFF_FFFF, 16'd4, 16'h0100, 1'b1, 16'h0105, 1'b0, 1'b0, 1'b0, 8'd4},
        // R3 SLT narrow: low half negative
        '{8'hce, 64'h0000_0000_8000_0000, 64'd0, 32'd0, 16'd4, 16'h0100, 1'b1, 16'h0105, 1'b0, 1'b0, 1'b0, 8'd3},
        // R6 GE narrow imm, equal low halves
        '{8'h36, 64'hFFFF_FFFF_0000_0005, 64'd0, 32'd5, 16'd4, 16'h0100, 1'b1, 16'h0105, 1'b0, 1'b0, 1'b0, 8'd6},
        // R6 LE equal
        '{8'hbd, 64'd3, 64'd3, 32'd0, 16'd4, 16'h0100, 1'b1, 16'h0105, 1'b0, 1'b0, 1'b0, 8'd6},
        // R7 SGE min-negative >= 0 false
        '{8'h7d, 64'h8000_0000_0000_0000, 64'd0, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b0, 8'd7},
        // R7 SLE narrow -1 <= 0
        '{8'hd6, 64'h0000_0000_FFFF_FFFF, 64'd0, 32'd0, 16'd4, 16'h0100, 1'b1, 16'h0105, 1'b0, 1'b0, 1'b0, 8'd7},
        // R3 GT narrow: low half 0 > 1 false
        '{8'h26, 64'h1_0000_0000, 64'd0, 32'd1, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b0, 8'd3},
        // R9 JA with negative offset
        '{8'h05, 64'd0, 64'd0, 32'd0, 16'hFFFE, 16'h0100, 1'b1, 16'h00FF, 1'b0, 1'b0, 1'b0, 8'd9},
        // R10 call
        '{8'h85, 64'd0, 64'd0, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b1, 1'b0, 1'b0, 8'd10},
        // R10 exit
        '{8'h95, 64'd0, 64'd0, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b1, 1'b0, 8'd10},
        // R11 JA narrow
        '{8'h06, 64'd0, 64'd0, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b1, 8'd11},
        // R11 call narrow
        '{8'h86, 64'd0, 64'd0, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b1, 8'd11},
        // R11 unused relation 0xE
        '{8'he5, 64'd0, 64'd0, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b1, 8'd11},
        // R3 non-jump class
        '{8'h1c, 64'd5, 64'd5, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b1, 8'd3},
        // R8 target wraps
        '{8'h1d, 64'd9, 64'd9, 32'd0, 16'd0, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 8'd8},
        // R11 exit narrow
        '{8'h96, 64'd0, 64'd0, 32'd0, 16'd4, 16'h0100, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b1, 8'd11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm = '0;
    logic [15:0] offset = '0;
    logic [PCW-1:0] pc = '0;
    logic        out_valid, taken, call_stb, exit_stb, illegal;
    logic [PCW-1:0] next_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    branch_resolve u_branch_resolve (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .dst_val(dst_val), .src_val(src_val), .imm(imm), .offset(offset), .pc(pc),
        .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
        .call_stb(call_stb), .exit_stb(exit_stb), .illegal(illegal)
    );

    task automatic check_all(input string tag, input logic ev, input logic et,
                             input logic [PCW-1:0] en, input logic ec,
                             input logic ee, input logic ei);
        checks++;
        if (out_valid !== ev || taken !== et || next_pc !== en ||
            call_stb !== ec || exit_stb !== ee || illegal !== ei) begin
            failures++;
            $display("FAIL %s: got v=%b t=%b pc=%h c=%b e=%b i=%b exp v=%b t=%b pc=%h c=%b e=%b i=%b",
                     tag, out_valid, taken, next_pc, call_stb, exit_stb, illegal,
                     ev, et, en, ec, ee, ei);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs zero in reset
        check_all("R1 reset", 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset", 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            opcode = VECS[i].op; dst_val = VECS[i].a; src_val = VECS[i].b;
            imm = VECS[i].imm; offset = VECS[i].off; pc = VECS[i].pc;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check_all($sformatf("R%0d vec %0d", VECS[i].req, i), 1'b1, VECS[i].tk,
                      VECS[i].npc, VECS[i].cl, VECS[i].ex, VECS[i].il);
            // R12 exclusive flags
            checks++;
            if ($countones({taken, call_stb, exit_stb, illegal}) > 1) begin
                failures++;
                $display("FAIL R12 vec %0d: flags=%b exp at most one set", i,
                         {taken, call_stb, exit_stb, illegal});
            end
        end

        // R2 taken instruction then an idle cycle
        opcode = 8'h05; pc = 16'h0200; offset = 16'd3; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_all("R2 result after one clock", 1'b1, 1'b1, 16'h0204, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check_all("R2 idle quiet", 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);

        // R1 reset mid-stream clears a pending result
        opcode = 8'h85; in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check_all("R1 reset overrides", 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule